// File: doc/BRIEF.md
# Indirect Control Register Bridge

The block exposes a small bank of internal control registers to a 32-bit host bus through only two host-visible words: a command word and a data word. To change an internal register the host first loads the data word, then writes the command word with its start flag set, a direction bit cleared and the internal register address in the low byte. To fetch an internal register it writes the command word with the start flag and the direction bit set, polls until the flag drops, and then reads the data word.

The start flag doubles as a busy indicator. Hardware holds it high for a fixed number of clock cycles, set by a parameter, and clears it once the internal access has been carried out. While it is high, the bridge ignores further command and data writes, so that an access in flight cannot be disturbed. The internal bank holds a control word, a 48-bit station address split across a full-width low half and a 16-bit high half, and a 64-bit hash filter split into two words. Their current contents are driven on dedicated outputs for the logic they steer.

Top module: `csr_window_bridge`

## Requirements
- R1: After reset the command word, the data word, `ctrl_word`, `station_addr` and `hash_word` all read zero.
- R2: A host write to the command word (host offset 0) with bit 31 set, made while idle, starts an access. From the next cycle the command word reads bit 31 = 1, bit 30 = the direction (1 read, 0 write) and bits 7:0 = the internal address. Bit 31 stays high for exactly LAT cycles (default 4) and then reads 0.
- R3: A write access copies the data word (host offset 1) into the addressed internal register at the edge where busy clears. No internal register changes at any other time.
- R4: A read access places the addressed internal register value in the data word at the edge where busy clears.
- R5: A command write made while busy is high is ignored. The address, direction and timing of the access in flight are unchanged, and no second access takes place.
- R6: A data-word write made while busy is high is dropped. The in-flight access uses, or returns, the value it would have had without that write.
- R7: A command write with bit 31 clear starts nothing and leaves the command word unchanged.
- R8: An internal address outside the implemented set reads back zero, and a write to it changes no internal register.
- R9: The station-address high register keeps only bits 15:0 of a write. Its bits 31:16 read back zero.
- R10: `station_addr` carries byte k in bits 8k+7:8k. Bytes 0 to 3 come from the low register, with byte 0 in its bits 7:0. Bytes 4 and 5 come from bits 7:0 and 15:8 of the high register.
- R11: Internal addresses are 0x10 control word, 0x11 station low, 0x12 station high, 0x18 hash low and 0x19 hash high. `hash_word` is {hash high, hash low} and `ctrl_word` is the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one per cycle |
| host_addr | input | 2 | Host word select: 0 command word, 1 data word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Readback of the selected host word (combinational) |
| ctrl_word | output | 32 | Current control word |
| station_addr | output | 48 | Current 48-bit station address |
| hash_word | output | 64 | Current 64-bit hash filter |

## Verification
The completion of an access and a new host command can fall in the same clock edge, because busy is still high in the cycle its counter expires. The bench issues the next command so that its write edge is exactly the LAT-th edge after the start. It then judges that busy reads low one cycle later, that the command word still shows the old access, and that the targeted register was not touched. The same edge alignment is repeated with a data-word write during a read, where the completion must win over the dropped host write.

// File: rtl/irb_pkg.sv
package irb_pkg;

   localparam int NUM_REGS = 5;

   typedef enum logic [2:0] {
      IX_CTRL    = 3'd0,
      IX_STN_LO  = 3'd1,
      IX_STN_HI  = 3'd2,
      IX_HASH_LO = 3'd3,
      IX_HASH_HI = 3'd4
   } reg_idx_e;

   // Internal address of each bank slot.
   function automatic int unsigned reg_addr(int idx);
      case (idx)
         int'(IX_CTRL):    return 32'h10;
         int'(IX_STN_LO):  return 32'h11;
         int'(IX_STN_HI):  return 32'h12;
         int'(IX_HASH_LO): return 32'h18;
         default:          return 32'h19;
      endcase
   endfunction

   // Stored width of a slot: the station high half is narrow.
   function automatic int keep_w(int idx, int dw, int nw);
      return (idx == int'(IX_STN_HI)) ? nw : dw;
   endfunction

   // Bit offset of a slot inside the packed bank image.
   function automatic int slot_lsb(int idx, int dw, int nw);
      int s;
      s = 0;
      for (int j = 0; j < idx; j++) s += keep_w(j, dw, nw);
      return s;
   endfunction

   function automatic bit addr_known(int unsigned a);
      for (int i = 0; i < NUM_REGS; i++)
         if (reg_addr(i) == a) return 1'b1;
      return 1'b0;
   endfunction

endpackage

// File: rtl/irb_host_port.sv
module irb_host_port #(
   parameter int DATA_W   = 32,
   parameter int IADDR_W  = 8,
   parameter int HOST_AW  = 2,
   parameter int CMD_OFS  = 0,
   parameter int DATA_OFS = 1
) (
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   input  logic               busy,
   input  logic               rnw_q,
   input  logic [IADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0]  data_q,
   output logic               go,
   output logic               go_rnw,
   output logic [IADDR_W-1:0] go_addr,
   output logic               data_wr,
   output logic [DATA_W-1:0]  host_rdata
);

   localparam int START_BIT = DATA_W - 1;
   localparam int DIR_BIT   = DATA_W - 2;

   logic              cmd_sel;
   logic              data_sel;
   logic [DATA_W-1:0] cmd_view;

   assign cmd_sel  = (host_addr == HOST_AW'(CMD_OFS));
   assign data_sel = (host_addr == HOST_AW'(DATA_OFS));

   // Host side is locked out entirely while an access is in flight.
   assign go      = host_we && cmd_sel && host_wdata[START_BIT] && !busy;
   assign go_rnw  = host_wdata[DIR_BIT];
   assign go_addr = host_wdata[IADDR_W-1:0];
   assign data_wr = host_we && data_sel && !busy;

   always_comb begin
      cmd_view               = '0;
      cmd_view[START_BIT]    = busy;
      cmd_view[DIR_BIT]      = rnw_q;
      cmd_view[IADDR_W-1:0]  = addr_q;
   end

   always_comb begin
      if (cmd_sel)       host_rdata = cmd_view;
      else if (data_sel) host_rdata = data_q;
      else               host_rdata = '0;
   end

endmodule

// File: rtl/irb_sequencer.sv
module irb_sequencer #(
   parameter int DATA_W  = 32,
   parameter int IADDR_W = 8,
   parameter int LAT     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               go_rnw,
   input  logic [IADDR_W-1:0] go_addr,
   input  logic               data_wr,
   input  logic [DATA_W-1:0]  data_in,
   input  logic [DATA_W-1:0]  rd_data,
   output logic               busy,
   output logic               rnw_q,
   output logic [IADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0]  data_q,
   output logic               done
);

   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         rnw_q  <= 1'b0;
         addr_q <= '0;
      end else if (go) begin
         busy   <= 1'b1;
         rnw_q  <= go_rnw;
         addr_q <= go_addr;
      end else if (done) begin
         busy   <= 1'b0;
      end
   end

   generate
      if (LAT == 1) begin : g_single
         assign done = busy;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                  cnt <= '0;
            else if (go)                 cnt <= CW'(LAT - 1);
            else if (busy && cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign done = busy && (cnt == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              data_q <= '0;
      else if (data_wr)        data_q <= data_in;
      else if (done && rnw_q)  data_q <= rd_data;
   end

endmodule

// File: rtl/irb_regbank.sv
module irb_regbank
   import irb_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int IADDR_W  = 8,
   parameter int NARROW_W = 16,
   localparam int FLAT_W  = slot_lsb(NUM_REGS, DATA_W, NARROW_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic [FLAT_W-1:0]  bank_flat
);

   logic [NUM_REGS-1:0]        hit;
   logic [NUM_REGS*DATA_W-1:0] slot_rd;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_slot
         localparam int KEEP = keep_w(gi, DATA_W, NARROW_W);
         localparam int LSB  = slot_lsb(gi, DATA_W, NARROW_W);
         logic [KEEP-1:0] q;

         assign hit[gi] = (acc_addr == IADDR_W'(reg_addr(gi)));

         always_ff @(posedge clk) begin
            if (!rst_n)                q <= '0;
            else if (wr_en && hit[gi]) q <= wr_data[KEEP-1:0];
         end

         assign bank_flat[LSB +: KEEP]          = q;
         assign slot_rd[gi*DATA_W +: DATA_W]    = hit[gi] ? DATA_W'(q) : '0;
      end
   endgenerate

   // Unmatched addresses fall through as zero.
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++)
         rd_data = rd_data | slot_rd[i*DATA_W +: DATA_W];
   end

endmodule

// File: rtl/csr_window_bridge.sv
module csr_window_bridge
   import irb_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int IADDR_W  = 8,
   parameter int NARROW_W = 16,
   parameter int HOST_AW  = 2,
   parameter int CMD_OFS  = 0,
   parameter int DATA_OFS = 1,
   parameter int LAT      = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         host_we,
   input  logic [HOST_AW-1:0]           host_addr,
   input  logic [DATA_W-1:0]            host_wdata,
   output logic [DATA_W-1:0]            host_rdata,
   output logic [DATA_W-1:0]            ctrl_word,
   output logic [DATA_W+NARROW_W-1:0]   station_addr,
   output logic [2*DATA_W-1:0]          hash_word
);

   localparam int FLAT_W = slot_lsb(NUM_REGS, DATA_W, NARROW_W);
   localparam int L_CTRL = slot_lsb(int'(IX_CTRL), DATA_W, NARROW_W);
   localparam int L_SLO  = slot_lsb(int'(IX_STN_LO), DATA_W, NARROW_W);
   localparam int L_SHI  = slot_lsb(int'(IX_STN_HI), DATA_W, NARROW_W);
   localparam int L_HLO  = slot_lsb(int'(IX_HASH_LO), DATA_W, NARROW_W);
   localparam int L_HHI  = slot_lsb(int'(IX_HASH_HI), DATA_W, NARROW_W);

   generate
      if (DATA_W < 16 || DATA_W > 64) begin : g_bad_dw
         $error("DATA_W must lie in 16..64");
      end
      if (IADDR_W < 5 || IADDR_W > DATA_W - 2) begin : g_bad_aw
         $error("IADDR_W must hold the bank addresses and leave room for the flags");
      end
      if (NARROW_W < 1 || NARROW_W >= DATA_W) begin : g_bad_nw
         $error("NARROW_W must be narrower than DATA_W");
      end
      if (LAT < 1) begin : g_bad_lat
         $error("LAT must be at least 1");
      end
      if (CMD_OFS == DATA_OFS || CMD_OFS >= (1 << HOST_AW) || DATA_OFS >= (1 << HOST_AW)) begin : g_bad_ofs
         $error("host offsets must differ and fit HOST_AW");
      end
   endgenerate

   logic               go;
   logic               go_rnw;
   logic [IADDR_W-1:0] go_addr;
   logic               data_wr;
   logic               busy;
   logic               rnw_q;
   logic [IADDR_W-1:0] addr_q;
   logic [DATA_W-1:0]  data_q;
   logic               done;
   logic [DATA_W-1:0]  rd_data;
   logic [FLAT_W-1:0]  bank_flat;

   irb_host_port #(
      .DATA_W(DATA_W), .IADDR_W(IADDR_W), .HOST_AW(HOST_AW),
      .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS)
   ) u_host (
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .busy       (busy),
      .rnw_q      (rnw_q),
      .addr_q     (addr_q),
      .data_q     (data_q),
      .go         (go),
      .go_rnw     (go_rnw),
      .go_addr    (go_addr),
      .data_wr    (data_wr),
      .host_rdata (host_rdata)
   );

   irb_sequencer #(
      .DATA_W(DATA_W), .IADDR_W(IADDR_W), .LAT(LAT)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .go_rnw  (go_rnw),
      .go_addr (go_addr),
      .data_wr (data_wr),
      .data_in (host_wdata),
      .rd_data (rd_data),
      .busy    (busy),
      .rnw_q   (rnw_q),
      .addr_q  (addr_q),
      .data_q  (data_q),
      .done    (done)
   );

   irb_regbank #(
      .DATA_W(DATA_W), .IADDR_W(IADDR_W), .NARROW_W(NARROW_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (done && !rnw_q),
      .acc_addr  (addr_q),
      .wr_data   (data_q),
      .rd_data   (rd_data),
      .bank_flat (bank_flat)
   );

   assign ctrl_word    = bank_flat[L_CTRL +: DATA_W];
   assign station_addr = {bank_flat[L_SHI +: NARROW_W], bank_flat[L_SLO +: DATA_W]};
   assign hash_word    = {bank_flat[L_HHI +: DATA_W], bank_flat[L_HLO +: DATA_W]};

endmodule

// File: rtl/csr_window_bridge_chk.sv
module csr_window_bridge_chk
   import irb_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int IADDR_W  = 8,
   parameter int NARROW_W = 16,
   parameter int LAT      = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       busy,
   input logic                       rnw_q,
   input logic [IADDR_W-1:0]         addr_q,
   input logic [DATA_W-1:0]          data_q,
   input logic [DATA_W-1:0]          ctrl_word,
   input logic [DATA_W+NARROW_W-1:0] station_addr,
   input logic [2*DATA_W-1:0]        hash_word
);

   localparam int RW = $clog2(LAT + 1) + 1;

   logic [RW-1:0] busy_run;
   logic          known_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   assign known_q = addr_known(32'(addr_q));

   assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_run == RW'(LAT));

   assert_regs_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy) |-> ($stable(ctrl_word) && $stable(station_addr) && $stable(hash_word)));

   assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(addr_q) && $stable(rnw_q)));

   assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(data_q));

   assert_unimpl_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && (rnw_q || !known_q)) |->
         ($stable(ctrl_word) && $stable(station_addr) && $stable(hash_word)));

   assert_unimpl_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && rnw_q && !known_q) |-> data_q == '0);

   assert_narrow_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && rnw_q && addr_q == IADDR_W'(reg_addr(int'(IX_STN_HI)))) |->
         data_q[DATA_W-1:NARROW_W] == '0);

endmodule

bind csr_window_bridge csr_window_bridge_chk #(
   .DATA_W(DATA_W), .IADDR_W(IADDR_W), .NARROW_W(NARROW_W), .LAT(LAT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .rnw_q        (rnw_q),
   .addr_q       (addr_q),
   .data_q       (data_q),
   .ctrl_word    (ctrl_word),
   .station_addr (station_addr),
   .hash_word    (hash_word)
);

// File: tb/csr_window_bridge_tb.sv
module csr_window_bridge_tb;

   localparam int LAT = 4;
   localparam logic [1:0] CMD  = 2'd0;
   localparam logic [1:0] DATA = 2'd1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [1:0]  host_addr = 2'd0;
   logic [31:0] host_wdata = 32'd0;
   logic [31:0] host_rdata;
   logic [31:0] ctrl_word;
   logic [47:0] station_addr;
   logic [63:0] hash_word;

   int n_chk = 0;
   int n_err = 0;

   logic [31:0] model [256];

   always #10 clk = ~clk;

   csr_window_bridge #(.LAT(LAT)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_we      (host_we),
      .host_addr    (host_addr),
      .host_wdata   (host_wdata),
      .host_rdata   (host_rdata),
      .ctrl_word    (ctrl_word),
      .station_addr (station_addr),
      .hash_word    (hash_word)
   );

   function automatic bit is_known(int a);
      return a == 'h10 || a == 'h11 || a == 'h12 || a == 'h18 || a == 'h19;
   endfunction

   function automatic logic [31:0] pat(int a);
      return (32'h9E3779B9 * 32'(a + 1)) ^ 32'(a);
   endfunction

   function automatic logic [31:0] go_word(bit rnw, int a);
      return {1'b1, rnw, 22'd0, 8'(a)};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
      host_addr  = a;
      host_wdata = d;
      host_we    = 1'b1;
      @(negedge clk);
      host_we    = 1'b0;
   endtask

   task automatic hread(input logic [1:0] a, output logic [31:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic model_write(input int a, input logic [31:0] d);
      if (is_known(a)) model[a] = (a == 'h12) ? {16'd0, d[15:0]} : d;
   endtask

   task automatic iwrite(input int a, input logic [31:0] d);
      hwrite(DATA, d);
      hwrite(CMD, go_word(1'b0, a));
      repeat (LAT) @(negedge clk);
      model_write(a, d);
   endtask

   task automatic iread(input int a, output logic [31:0] d);
      hwrite(CMD, go_word(1'b1, a));
      repeat (LAT) @(negedge clk);
      hread(DATA, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] rv;
      logic [31:0] cmd_before;
      for (int i = 0; i < 256; i++) model[i] = 32'd0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      hread(CMD, rv);  check("R1 cmd", 64'(rv), 64'd0);
      hread(DATA, rv); check("R1 data", 64'(rv), 64'd0);
      check("R1 ctrl", 64'(ctrl_word), 64'd0);
      check("R1 station", 64'(station_addr), 64'd0);
      check("R1 hash", hash_word, 64'd0);
      @(negedge clk);

      // R2: busy window and command readback
      hwrite(CMD, go_word(1'b1, 'h10));
      hread(CMD, rv); check("R2 cmd view", 64'(rv), 64'(go_word(1'b1, 'h10)));
      for (int k = 1; k < LAT; k++) begin
         @(negedge clk);
         hread(CMD, rv); check("R2 busy held", 64'(rv[31]), 64'd1);
      end
      @(negedge clk);
      hread(CMD, rv); check("R2 busy cleared", 64'(rv), 64'(32'h4000_0010));

      // R11 / R3 / R4: named registers
      iwrite('h10, 32'hC0DE_0001);
      check("R11 ctrl_word", 64'(ctrl_word), 64'h00000000C0DE0001);
      iwrite('h18, 32'h1234_5678);
      iwrite('h19, 32'h9ABC_DEF0);
      check("R11 hash_word", hash_word, 64'h9ABCDEF012345678);
      iread('h19, rv); check("R4 hash hi read", 64'(rv), 64'h9ABCDEF0);

      // R10: station byte packing
      iwrite('h11, 32'h4433_2211);
      iwrite('h12, 32'hFFFF_6655);
      check("R10 station", 64'(station_addr), 64'h0000665544332211);
      for (int b = 0; b < 6; b++)
         check("R10 byte", 64'(station_addr[8*b +: 8]), 64'(8'h11 * (b + 1)));
      // R9: high half narrow
      iread('h12, rv); check("R9 station hi readback", 64'(rv), 64'h6655);

      // R7: command without start bit
      hread(CMD, cmd_before);
      hwrite(CMD, {1'b0, 1'b0, 22'd0, 8'h10});
      hread(CMD, rv); check("R7 cmd unchanged", 64'(rv), 64'(cmd_before));
      repeat (LAT) @(negedge clk);
      check("R7 ctrl unchanged", 64'(ctrl_word), 64'hC0DE0001);

      // R5: command during busy, mid-window
      hwrite(DATA, 32'hA5A5_0F0F);
      hwrite(CMD, go_word(1'b0, 'h10));
      hwrite(CMD, go_word(1'b1, 'h18));
      hread(CMD, rv); check("R5 cmd held", 64'(rv), 64'(go_word(1'b0, 'h10)));
      repeat (LAT - 1) @(negedge clk);
      hread(CMD, rv); check("R5 timing kept", 64'(rv[31]), 64'd0);
      model_write('h10, 32'hA5A5_0F0F);
      check("R5 write landed", 64'(ctrl_word), 64'hA5A50F0F);
      hread(DATA, rv); check("R5 no second read", 64'(rv), 64'hA5A50F0F);

      // R5: command on the completion edge
      hwrite(DATA, 32'h0000_7777);
      hwrite(CMD, go_word(1'b0, 'h18));
      repeat (LAT - 1) @(negedge clk);
      hwrite(CMD, go_word(1'b0, 'h10));
      model_write('h18, 32'h0000_7777);
      hread(CMD, rv); check("R5 edge cmd dropped", 64'(rv), 64'(32'h0000_0018));
      repeat (LAT + 1) @(negedge clk);
      check("R5 edge ctrl untouched", 64'(ctrl_word), 64'hA5A50F0F);
      check("R3 hash lo written", 64'(hash_word[31:0]), 64'h7777);

      // R6: data write during a read, including on the completion edge
      hwrite(CMD, go_word(1'b1, 'h11));
      hwrite(DATA, 32'hDEAD_BEEF);
      repeat (LAT - 2) @(negedge clk);
      hwrite(DATA, 32'hFEED_F00D);
      hread(DATA, rv); check("R6 read result kept", 64'(rv), 64'h44332211);
      // R6: data write during a write
      hwrite(DATA, 32'h0102_0304);
      hwrite(CMD, go_word(1'b0, 'h19));
      hwrite(DATA, 32'hBAD0_BAD0);
      repeat (LAT - 1) @(negedge clk);
      model_write('h19, 32'h0102_0304);
      check("R6 write data kept", 64'(hash_word[63:32]), 64'h01020304);

      // Sweep: every internal address (R3, R4, R8, R9)
      for (int a = 0; a < 256; a++) iwrite(a, pat(a));
      for (int a = 0; a < 256; a++) begin
         iread(a, rv);
         if (is_known(a)) check("R4 sweep read", 64'(rv), 64'(model[a]));
         else             check("R8 unimplemented reads zero", 64'(rv), 64'd0);
      end
      check("R3 sweep ctrl", 64'(ctrl_word), 64'(model['h10]));
      check("R9 sweep station", 64'(station_addr), {16'd0, model['h12][15:0], model['h11]});
      check("R8 sweep hash", hash_word, {model['h19], model['h18]});

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule